// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. It takes either its own pin or the XOR of three channel pins and brings that signal into the timer clock domain. A digital noise filter then cleans it, and an edge detector with selectable polarity looks for the events of interest. The capture trigger can come from this channel's filtered input, from the filtered input of a paired neighbour channel, or from an internal trigger line. A prescaler can merge several trigger events into one capture.

On each effective capture, the value of the free-running timer counter is stored in the capture register and a flag is raised. If the flag is still set when another capture arrives, an overcapture flag is also set. The interrupt line follows the flag while the interrupt enable is set. A one-cycle DMA request pulse follows each capture while DMA is enabled. The counter, the register bus and the other channels sit outside the block and appear only as ports. The filtered input is brought out so that a neighbour channel can use it.

Top module: `tmr_cap_chan`

## Requirements
- R1: After reset, the capture register, both flags, the interrupt and the DMA request are all 0.
- R2: In mode 1 with rising polarity and the filter bypassed, a 0 to 1 change on the own pin, applied before clock edge k, stores the counter value sampled at edge k+3. This latency covers two synchronizer stages, the filter register and the edge register.
- R3: With filter setting s (0, 1, 2 or 3), the filtered signal changes only after N consecutive differing samples, where N is 1, 2, 4 or 8. At N=4, a pulse held for 3 samples causes no capture, and a held change is captured at edge k+6.
- R4: Edge select 2'b00 (and 2'b10) captures on rising edges, 2'b01 on falling edges, and 2'b11 on both edges.
- R5: When the XOR select is set, the channel input is pin0 XOR pin1 XOR pin2, and the own pin has no effect.
- R6: Mode 2 triggers on the paired channel's filtered input, and mode 3 triggers on the internal trigger. Both are edge-detected directly, so an edge present before edge k is captured with the counter value at edge k.
- R7: Mode 0 is output mode, in which no capture occurs.
- R8: Prescaler code p gives a ratio of 2^p, so only every 2^p-th qualifying event captures. The event count returns to zero whenever capture is disabled.
- R9: While the capture enable is low, the capture register and the flag do not change through captures.
- R10: The interrupt equals the flag gated by the interrupt enable. With DMA enabled, each capture produces exactly one one-cycle DMA request pulse, in the cycle after the capture edge.
- R11: A software write to the capture register takes effect only in mode 0. In modes 1 to 3 it is ignored.
- R12: A capture while the flag is set also sets the overcapture flag. A clear pulse resets both flags, but a capture on the same edge as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_own | input | 1 | This channel's pin |
| pin0 | input | 1 | Channel pin 0 for the XOR input |
| pin1 | input | 1 | Channel pin 1 for the XOR input |
| pin2 | input | 1 | Channel pin 2 for the XOR input |
| xor_sel | input | 1 | Select the XOR of pin0..pin2 as the input |
| pair_in | input | 1 | Filtered input of the paired channel |
| itrig | input | 1 | Internal trigger |
| cnt | input | CW | Free-running counter value |
| filt_cfg | input | 2 | Filter setting: N = 1, 2, 4, 8 |
| edge_sel | input | 2 | Polarity: 00 rise, 01 fall, 11 both |
| mode | input | 2 | 0 output, 1 own, 2 paired, 3 internal trigger |
| psc | input | 2 | Prescaler ratio code, ratio 2^psc |
| cap_en | input | 1 | Capture enable |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| flag_clr | input | 1 | Clear both flags |
| sw_we | input | 1 | Software write strobe for the capture register |
| sw_wdata | input | CW | Software write data |
| ccr | output | CW | Capture register |
| flag | output | 1 | Capture flag |
| ovr | output | 1 | Overcapture flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request pulse |
| filt_out | output | 1 | This channel's filtered input |

## Verification
The assertions assume that the configuration inputs are static, or change only while the capture enable is low, so that a mode or source switch cannot create a spurious edge. They also assume that a clear is a plain pulse not tied to any particular capture. The bench follows these assumptions. Every scenario first drops the capture enable, sets the configuration and idle pin levels, and waits longer than the slowest filter plus the synchronizer. Only then does it clear the flags and enable capture. Input changes are applied away from the clock edge, and capture values are predicted from the counter value at the moment of the change plus the stated pipeline latency.

// File: rtl/tmr_cap_chan.sv
module tmr_cap_chan #(
  parameter int CW = 16,
  parameter int FCW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_own,
  input  logic          pin0,
  input  logic          pin1,
  input  logic          pin2,
  input  logic          xor_sel,
  input  logic          pair_in,
  input  logic          itrig,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    filt_cfg,
  input  logic [1:0]    edge_sel,
  input  logic [1:0]    mode,
  input  logic [1:0]    psc,
  input  logic          cap_en,
  input  logic          irq_en,
  input  logic          dma_en,
  input  logic          flag_clr,
  input  logic          sw_we,
  input  logic [CW-1:0] sw_wdata,
  output logic [CW-1:0] ccr,
  output logic          flag,
  output logic          ovr,
  output logic          irq,
  output logic          dma_req,
  output logic          filt_out
);
  localparam int NW = FCW + 1;

  logic s1, s2, fq, src, src_d, rise, fall, evt, active, fire;
  logic [FCW-1:0] fc;
  logic [NW-1:0]  need;
  logic [2:0]     pcnt, pmax;

  wire in_raw = xor_sel ? (pin0 ^ pin1 ^ pin2) : pin_own;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= in_raw;
      s2 <= s1;
    end

  always_comb
    case (filt_cfg)
      2'd0:    need = NW'(1);
      2'd1:    need = NW'(2);
      2'd2:    need = NW'(4);
      default: need = NW'(8);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fq <= 1'b0;
      fc <= '0;
    end else if (s2 == fq) begin
      fc <= '0;
    end else if ({1'b0, fc} + NW'(1) >= need) begin
      fq <= s2;
      fc <= '0;
    end else begin
      fc <= fc + FCW'(1);
    end

  assign filt_out = fq;

  always_comb
    case (mode)
      2'd1:    src = fq;
      2'd2:    src = pair_in;
      2'd3:    src = itrig;
      default: src = 1'b0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_d <= 1'b0;
    else        src_d <= src;

  assign rise   = src & ~src_d;
  assign fall   = ~src & src_d;
  assign evt    = (edge_sel == 2'b11) ? (rise | fall) :
                  (edge_sel == 2'b01) ? fall : rise;
  assign active = cap_en && (mode != 2'd0);
  assign pmax   = 3'((4'd1 << psc) - 4'd1);
  assign fire   = active && evt && (pcnt == pmax);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pcnt <= '0;
    else if (!active) pcnt <= '0;
    else if (evt)     pcnt <= fire ? 3'd0 : pcnt + 3'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ccr     <= '0;
      flag    <= 1'b0;
      ovr     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (fire)                          ccr <= cnt;
      else if (sw_we && mode == 2'd0)    ccr <= sw_wdata;
      if (fire)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (fire && flag)  ovr <= 1'b1;
      else if (flag_clr) ovr <= 1'b0;
      dma_req <= fire && dma_en;
    end

  assign irq = flag & irq_en;
endmodule

// File: rtl/tmr_cap_chan_chk.sv
module tmr_cap_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          cap_en,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          sw_we,
  input logic [CW-1:0] ccr,
  input logic          flag,
  input logic          ovr,
  input logic          irq,
  input logic          dma_req
);
  p_hold_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && !cap_en) |=> $stable(ccr));

  p_mode0_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !sw_we) |=> $stable(ccr));

  p_clear_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_en) |=> (!flag && !ovr));

  p_ovr_after_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(flag));

  p_dma_with_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> flag);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_no_flag_mode0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !flag) |=> !flag);
endmodule

bind tmr_cap_chan tmr_cap_chan_chk #(.CW(CW)) u_chk (
  .clk, .rst_n, .mode, .cap_en, .irq_en, .flag_clr, .sw_we,
  .ccr, .flag, .ovr, .irq, .dma_req
);

// File: tb/sim_tmr_cap_chan.sv
`timescale 1ns/1ps
module sim_tmr_cap_chan;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_own = 0, pin0 = 0, pin1 = 0, pin2 = 0, xor_sel = 0;
  logic pair_in = 0, itrig = 0;
  logic [CW-1:0] cnt;
  logic [1:0] filt_cfg = 0, edge_sel = 0, mode = 0, psc = 0;
  logic cap_en = 0, irq_en = 0, dma_en = 0, flag_clr = 0, sw_we = 0;
  logic [CW-1:0] sw_wdata = 0;
  logic [CW-1:0] ccr;
  logic flag, ovr, irq, dma_req, filt_out;

  int n_run = 0, n_fail = 0;
  logic [CW-1:0] c0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;

  tmr_cap_chan #(.CW(CW)) u0 (
    .clk, .rst_n, .pin_own, .pin0, .pin1, .pin2, .xor_sel, .pair_in, .itrig,
    .cnt, .filt_cfg, .edge_sel, .mode, .psc, .cap_en, .irq_en, .dma_en,
    .flag_clr, .sw_we, .sw_wdata, .ccr, .flag, .ovr, .irq, .dma_req, .filt_out
  );

  task automatic chk(input string req, input longint got, input longint exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] es,
                       input logic [1:0] fc, input logic [1:0] p, input logic xs);
    @(negedge clk);
    cap_en = 0; mode = m; edge_sel = es; filt_cfg = fc; psc = p; xor_sel = xs;
    pin_own = 0; pin0 = 0; pin1 = 0; pin2 = 0; pair_in = 0; itrig = 0;
    cyc(20);
    flag_clr = 1; cyc(1); flag_clr = 0;
    cap_en = 1; cyc(2);
  endtask

  task automatic t_reset;
    chk("R1 ccr", ccr, 0); chk("R1 flag", flag, 0); chk("R1 ovr", ovr, 0);
    chk("R1 irq", irq, 0); chk("R1 dma", dma_req, 0);
  endtask

  task automatic t_own_rise;
    setup(2'd1, 2'b00, 2'd0, 2'd0, 0);
    c0 = cnt; pin_own = 1; cyc(3);
    chk("R2 no capture yet", flag, 0);
    cyc(1);
    chk("R2 flag", flag, 1); chk("R2 ccr", ccr, c0 + 3);
  endtask

  task automatic t_filter;
    setup(2'd1, 2'b00, 2'd2, 2'd0, 0);
    pin_own = 1; cyc(3); pin_own = 0; cyc(12);
    chk("R3 glitch rejected", flag, 0);
    c0 = cnt; pin_own = 1; cyc(12);
    chk("R3 flag", flag, 1); chk("R3 ccr", ccr, c0 + 6);
  endtask

  task automatic t_fall;
    setup(2'd1, 2'b01, 2'd0, 2'd0, 0);
    pin_own = 1; cyc(10);
    chk("R4 rise ignored", flag, 0);
    c0 = cnt; pin_own = 0; cyc(10);
    chk("R4 fall ccr", ccr, c0 + 3); chk("R4 fall flag", flag, 1);
  endtask

  task automatic t_both;
    setup(2'd1, 2'b11, 2'd0, 2'd0, 0);
    c0 = cnt; pin_own = 1; cyc(10);
    chk("R4 both rise", ccr, c0 + 3);
    c0 = cnt; pin_own = 0; cyc(10);
    chk("R4 both fall", ccr, c0 + 3);
  endtask

  task automatic t_xor;
    setup(2'd1, 2'b00, 2'd0, 2'd0, 1);
    pin_own = 1; cyc(10);
    chk("R5 own pin ignored", flag, 0);
    c0 = cnt; pin1 = 1; cyc(10);
    chk("R5 xor capture", ccr, c0 + 3);
  endtask

  task automatic t_sources;
    setup(2'd2, 2'b00, 2'd0, 2'd0, 0);
    pin_own = 1; cyc(10);
    chk("R6 own ignored in paired", flag, 0);
    c0 = cnt; pair_in = 1; cyc(4);
    chk("R6 paired ccr", ccr, c0);
    setup(2'd3, 2'b00, 2'd0, 2'd0, 0);
    c0 = cnt; itrig = 1; cyc(4);
    chk("R6 itrig ccr", ccr, c0);
    setup(2'd0, 2'b00, 2'd0, 2'd0, 0);
    pin_own = 1; itrig = 1; pair_in = 1; cyc(10);
    chk("R7 output mode no capture", flag, 0);
  endtask

  task automatic t_psc;
    setup(2'd1, 2'b00, 2'd0, 2'd2, 0);
    for (int i = 0; i < 3; i++) begin
      pin_own = 1; cyc(4); pin_own = 0; cyc(4);
    end
    chk("R8 three events no capture", flag, 0);
    c0 = cnt; pin_own = 1; cyc(6);
    chk("R8 fourth event ccr", ccr, c0 + 3);
    pin_own = 0; cyc(4);
    flag_clr = 1; cyc(1); flag_clr = 0;
    pin_own = 1; cyc(4); pin_own = 0; cyc(4);
    cap_en = 0; cyc(2); cap_en = 1; cyc(2);
    for (int i = 0; i < 3; i++) begin
      pin_own = 1; cyc(4); pin_own = 0; cyc(4);
    end
    chk("R8 count reset by disable", flag, 0);
  endtask

  task automatic t_disable;
    setup(2'd1, 2'b00, 2'd0, 2'd0, 0);
    c0 = cnt; pin_own = 1; cyc(8);
    chk("R9 baseline ccr", ccr, c0 + 3);
    flag_clr = 1; cyc(1); flag_clr = 0;
    cap_en = 0; pin_own = 0; cyc(4); pin_own = 1; cyc(8);
    chk("R9 flag unchanged", flag, 0); chk("R9 ccr unchanged", ccr, c0 + 3);
  endtask

  task automatic t_irq_dma;
    int pulses;
    setup(2'd1, 2'b00, 2'd0, 2'd0, 0);
    dma_en = 1; irq_en = 0; pulses = 0;
    pin_own = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dma_req) pulses++;
    end
    chk("R10 dma single pulse", pulses, 1);
    chk("R10 irq masked", irq, 0);
    irq_en = 1; cyc(1);
    chk("R10 irq follows flag", irq, 1);
    irq_en = 0; dma_en = 0;
  endtask

  task automatic t_sw;
    setup(2'd1, 2'b00, 2'd0, 2'd0, 0);
    sw_wdata = 16'h1234; sw_we = 1; cyc(1); sw_we = 0; cyc(1);
    chk("R11 write ignored in input mode", ccr != 16'h1234, 1);
    setup(2'd0, 2'b00, 2'd0, 2'd0, 0);
    sw_wdata = 16'hBEEF; sw_we = 1; cyc(1); sw_we = 0; cyc(1);
    chk("R11 write in output mode", ccr, 16'hBEEF);
  endtask

  task automatic t_ovr;
    setup(2'd1, 2'b11, 2'd0, 2'd0, 0);
    pin_own = 1; cyc(8);
    chk("R12 no ovr after one", ovr, 0);
    pin_own = 0; cyc(8);
    chk("R12 ovr set", ovr, 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R12 clear flag", flag, 0); chk("R12 clear ovr", ovr, 0);
    c0 = cnt; pin_own = 1; cyc(3);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R12 capture beats clear", flag, 1);
    chk("R12 capture beats clear ccr", ccr, c0 + 3);
  endtask

  initial begin
    cyc(3); rst_n = 1;
    @(negedge clk);
    t_reset();
    t_own_rise();
    t_filter();
    t_fall();
    t_both();
    t_xor();
    t_sources();
    t_psc();
    t_disable();
    t_irq_dma();
    t_sw();
    t_ovr();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule